// File: doc/BRIEF.md
# Palettized Frame Scan-Out with Dirty-Row Coalescing

This block walks a frame of 8-bit pixel indices row by row, for a width and height given when the scan starts. Each row is either refreshed or skipped. A row is refreshed when its dirty bit is set or when a pending full-refresh flag forces every row. For a refreshed row, the block reads the pixel indices in address order and converts each one through a 256-entry colour table into a 32-bit `0x00RRGGBB` word. For a skipped row, the block makes no pixel reads, but its address still advances by one row width.

Neighbouring refreshed rows are merged into one update region. The block reports each region on a valid/ready channel as a first row and a row count. Once the scan and all its reports are finished, a single-cycle end-of-frame strobe is raised, which the system can use as a vertical-sync interrupt source. Writing a colour-table entry, or pulsing the invalidate input, arms the full-refresh flag for the next scan.

Pixel memory sits outside the block. It must return the index for `pix_addr_o` one cycle after `pix_rd_o`. The coloured pixel appears on `px_rgb_o` two cycles after its read.

Top module: `pal_scanout`

## Requirements
- R1: Every output pixel equals `{8'h00, entry}`, where entry is the 24-bit colour-table word addressed by the pixel index. A table write stores `pal_rgb_i` (red in bits 23:16, green in 15:8, blue in 7:0) at `pal_idx_i`. Pixels come out in read order.
- R2: While reset is held, `busy_o`, `px_valid_o`, `rng_valid_o` and `eof_o` are low and `full_o` is high.
- R3: When the full-refresh flag was set at scan start, every row from 0 to height-1 is read, and exactly one region (start 0, count height) is reported.
- R4: A refreshed row r is read at addresses r*width to r*width+width-1, in rising order. A skipped row causes no read.
- R5: A run of consecutive refreshed rows is reported as one region, at the first skipped row after it, before any read of a later row.
- R6: A run still open at the last row is reported before the end-of-frame strobe.
- R7: The full-refresh flag (`full_o`) is low after a scan ends, unless a table write or invalidate arrived while that scan was busy, in which case it stays high.
- R8: A table write or an invalidate pulse makes `full_o` high on the next cycle.
- R9: Each scan produces exactly one `eof_o` pulse of one cycle, after its last region handshake, and `busy_o` is low on the following cycle.
- R10: While `rng_valid_o` is high and `rng_ready_i` is low, the region stays offered and its start and count stay unchanged.
- R11: `start_i` is ignored while busy. `dirty_i` is sampled only in the cycle a scan starts, so later changes have no effect on that scan.
- R12: Bit r of `dirty_i` marks row r. Bits at or above the scan height have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame scan when idle |
| width_i | input | XW | Pixels per row (1..MAX_W), sampled at start |
| height_i | input | YW | Rows per frame (1..MAX_H), sampled at start |
| dirty_i | input | MAX_H | Per-row dirty bits, sampled at start |
| inval_i | input | 1 | Request a full refresh |
| pal_we_i | input | 1 | Colour-table write strobe |
| pal_idx_i | input | PIX_W | Colour-table write index |
| pal_rgb_i | input | 3*CH_W | Colour-table write data {R,G,B} |
| pix_rd_o | output | 1 | Pixel read request |
| pix_addr_o | output | AW | Pixel read address |
| pix_idx_i | input | PIX_W | Pixel index, one cycle after the read |
| px_valid_o | output | 1 | Coloured pixel valid |
| px_rgb_o | output | 4*CH_W | Coloured pixel {0,R,G,B} |
| rng_valid_o | output | 1 | Update region offered |
| rng_ready_i | input | 1 | Update region accepted |
| rng_start_o | output | YW | First row of region |
| rng_count_o | output | YW | Rows in region |
| eof_o | output | 1 | End-of-frame strobe |
| busy_o | output | 1 | Scan in progress |
| full_o | output | 1 | Full-refresh flag pending |

## Verification
The bench builds the block with MAX_W = 8 and MAX_H = 8, keeping the 8-bit index and 8-bit channels. This lets frames of full width and full height be walked in a few dozen cycles. It also covers rows beyond a short height, one-pixel rows, single-row frames and alternating dirty patterns, each as many times as needed. A region ready line that toggles every cycle exercises backpressure on region reports. Separate tests cover a table write or invalidate arriving in the middle of a scan, and a restart attempt with changed dirty bits while busy.

// File: rtl/pal_scanout_pkg.sv
package pal_scanout_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_RPT  = 2'd2,
    ST_END  = 2'd3
  } walk_st_e;
endpackage

// File: rtl/pal_lut.sv
module pal_lut #(
  parameter int PIX_W = 8,
  parameter int CH_W  = 8,
  localparam int RGB_W = 3 * CH_W,
  localparam int OUT_W = 4 * CH_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PIX_W-1:0] widx_i,
  input  logic [RGB_W-1:0] wrgb_i,
  input  logic             rd_i,
  input  logic [PIX_W-1:0] ridx_i,
  output logic             vld_o,
  output logic [OUT_W-1:0] rgb_o
);
  localparam int DEPTH = 2 ** PIX_W;

  logic [RGB_W-1:0] mem_q [DEPTH];
  logic [RGB_W-1:0] ent;
  logic [OUT_W-1:0] word;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wrgb_i;
  end

  assign ent = mem_q[ridx_i];

  // channel c of the entry lands in byte lane c of the output word
  for (genvar c = 0; c < 3; c++) begin : g_ch
    assign word[c*CH_W +: CH_W] = ent[c*CH_W +: CH_W];
  end
  assign word[OUT_W-1 -: CH_W] = '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      rgb_o <= '0;
    end else begin
      vld_o <= rd_i;
      if (rd_i) rgb_o <= word;
    end
  end
endmodule

// File: rtl/dirty_rows.sv
module dirty_rows #(
  parameter int MAX_H = 16,
  localparam int YW = $clog2(MAX_H + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [MAX_H-1:0] vec_i,
  input  logic             clr_i,
  input  logic [YW-1:0]    row_i,
  output logic             bit_o
);
  logic [MAX_H-1:0] vec_q;
  logic [MAX_H-1:0] hit;

  for (genvar i = 0; i < MAX_H; i++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             vec_q[i] <= 1'b0;
      else if (load_i)                         vec_q[i] <= vec_i[i];
      else if (clr_i && row_i == YW'(i))       vec_q[i] <= 1'b0;
    end
    assign hit[i] = vec_q[i] && (row_i == YW'(i));
  end

  assign bit_o = |hit;
endmodule

// File: rtl/full_flag.sv
module full_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic load_i,
  input  logic eof_i,
  input  logic busy_i,
  output logic full_o,
  output logic frame_full_o
);
  logic rearm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o       <= 1'b1;
      frame_full_o <= 1'b0;
      rearm_q      <= 1'b0;
    end else begin
      if (load_i) frame_full_o <= full_o | set_i;
      // requests seen during a scan survive its end
      if (load_i)                 rearm_q <= 1'b0;
      else if (set_i && busy_i)   rearm_q <= 1'b1;
      if (eof_i)                  full_o <= rearm_q | set_i;
      else if (set_i)             full_o <= 1'b1;
    end
  end
endmodule

// File: rtl/row_walker.sv
module row_walker
  import pal_scanout_pkg::*;
#(
  parameter int MAX_W = 16,
  parameter int MAX_H = 16,
  localparam int XW = $clog2(MAX_W + 1),
  localparam int YW = $clog2(MAX_H + 1),
  localparam int AW = $clog2(MAX_W * MAX_H)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [XW-1:0] width_i,
  input  logic [YW-1:0] height_i,
  input  logic          full_i,
  input  logic          dirty_bit_i,
  input  logic          rng_ready_i,
  output logic          load_o,
  output logic          consume_o,
  output logic [YW-1:0] row_o,
  output logic          pix_rd_o,
  output logic [AW-1:0] pix_addr_o,
  output logic          rng_valid_o,
  output logic [YW-1:0] rng_start_o,
  output logic [YW-1:0] rng_count_o,
  output logic          eof_o,
  output logic          busy_o
);
  walk_st_e      st_q;
  logic [XW-1:0] w_q, col_q;
  logic [YW-1:0] h_q, row_q, run_start_q, run_len_q;
  logic [AW-1:0] base_q;
  logic          last_q;
  logic          cur_dirty, row_last, col_last, row_done;

  always_comb begin
    cur_dirty = full_i | dirty_bit_i;
    row_last  = (row_q == h_q - YW'(1));
    col_last  = (col_q == w_q - XW'(1));
    row_done  = (st_q == ST_SCAN) && (!cur_dirty || col_last);
  end

  assign load_o      = (st_q == ST_IDLE) && start_i;
  assign consume_o   = row_done;
  assign row_o       = row_q;
  assign pix_rd_o    = (st_q == ST_SCAN) && cur_dirty;
  assign pix_addr_o  = base_q + AW'(col_q);
  assign rng_valid_o = (st_q == ST_RPT);
  assign eof_o       = (st_q == ST_END);
  assign busy_o      = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      w_q         <= '0;
      h_q         <= '0;
      col_q       <= '0;
      row_q       <= '0;
      base_q      <= '0;
      run_start_q <= '0;
      run_len_q   <= '0;
      rng_start_o <= '0;
      rng_count_o <= '0;
      last_q      <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          w_q       <= width_i;
          h_q       <= height_i;
          col_q     <= '0;
          row_q     <= '0;
          base_q    <= '0;
          run_len_q <= '0;
          last_q    <= 1'b0;
          st_q      <= ST_SCAN;
        end
        ST_SCAN: if (row_done) begin
          col_q  <= '0;
          base_q <= base_q + AW'(w_q);
          row_q  <= row_q + YW'(1);
          if (cur_dirty) begin
            if (run_len_q == '0) run_start_q <= row_q;
            run_len_q <= run_len_q + YW'(1);
            if (row_last) begin
              rng_start_o <= (run_len_q == '0) ? row_q : run_start_q;
              rng_count_o <= run_len_q + YW'(1);
              last_q      <= 1'b1;
              st_q        <= ST_RPT;
            end
          end else begin
            run_len_q <= '0;
            if (run_len_q != '0) begin
              rng_start_o <= run_start_q;
              rng_count_o <= run_len_q;
              last_q      <= row_last;
              st_q        <= ST_RPT;
            end else if (row_last) begin
              st_q <= ST_END;
            end
          end
        end else begin
          col_q <= col_q + XW'(1);
        end
        ST_RPT: if (rng_ready_i) st_q <= last_q ? ST_END : ST_SCAN;
        ST_END: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pal_scanout.sv
module pal_scanout #(
  parameter int MAX_W = 16,
  parameter int MAX_H = 16,
  parameter int PIX_W = 8,
  parameter int CH_W  = 8,
  localparam int XW    = $clog2(MAX_W + 1),
  localparam int YW    = $clog2(MAX_H + 1),
  localparam int AW    = $clog2(MAX_W * MAX_H),
  localparam int RGB_W = 3 * CH_W,
  localparam int OUT_W = 4 * CH_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [XW-1:0]    width_i,
  input  logic [YW-1:0]    height_i,
  input  logic [MAX_H-1:0] dirty_i,
  input  logic             inval_i,
  input  logic             pal_we_i,
  input  logic [PIX_W-1:0] pal_idx_i,
  input  logic [RGB_W-1:0] pal_rgb_i,
  output logic             pix_rd_o,
  output logic [AW-1:0]    pix_addr_o,
  input  logic [PIX_W-1:0] pix_idx_i,
  output logic             px_valid_o,
  output logic [OUT_W-1:0] px_rgb_o,
  output logic             rng_valid_o,
  input  logic             rng_ready_i,
  output logic [YW-1:0]    rng_start_o,
  output logic [YW-1:0]    rng_count_o,
  output logic             eof_o,
  output logic             busy_o,
  output logic             full_o
);
  logic          load, consume, dirty_bit, frame_full, rd_d1;
  logic [YW-1:0] row;

  full_flag i_full (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (pal_we_i | inval_i),
    .load_i       (load),
    .eof_i        (eof_o),
    .busy_i       (busy_o),
    .full_o       (full_o),
    .frame_full_o (frame_full)
  );

  dirty_rows #(.MAX_H(MAX_H)) i_dirty (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .vec_i  (dirty_i),
    .clr_i  (consume),
    .row_i  (row),
    .bit_o  (dirty_bit)
  );

  row_walker #(.MAX_W(MAX_W), .MAX_H(MAX_H)) i_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .width_i     (width_i),
    .height_i    (height_i),
    .full_i      (frame_full),
    .dirty_bit_i (dirty_bit),
    .rng_ready_i (rng_ready_i),
    .load_o      (load),
    .consume_o   (consume),
    .row_o       (row),
    .pix_rd_o    (pix_rd_o),
    .pix_addr_o  (pix_addr_o),
    .rng_valid_o (rng_valid_o),
    .rng_start_o (rng_start_o),
    .rng_count_o (rng_count_o),
    .eof_o       (eof_o),
    .busy_o      (busy_o)
  );

  // pixel memory answers one cycle after the read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_d1 <= 1'b0;
    else         rd_d1 <= pix_rd_o;
  end

  pal_lut #(.PIX_W(PIX_W), .CH_W(CH_W)) i_lut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (pal_we_i),
    .widx_i (pal_idx_i),
    .wrgb_i (pal_rgb_i),
    .rd_i   (rd_d1),
    .ridx_i (pix_idx_i),
    .vld_o  (px_valid_o),
    .rgb_o  (px_rgb_o)
  );
endmodule

// File: rtl/pal_scanout_chk.sv
module pal_scanout_chk #(
  parameter int MAX_H = 16,
  localparam int YW = $clog2(MAX_H + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          inval_i,
  input logic          pal_we_i,
  input logic          pix_rd_o,
  input logic          px_valid_o,
  input logic          rng_valid_o,
  input logic          rng_ready_i,
  input logic [YW-1:0] rng_start_o,
  input logic [YW-1:0] rng_count_o,
  input logic          eof_o,
  input logic          busy_o,
  input logic          full_o
);
  // R10
  rng_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rng_valid_o && !rng_ready_i |=> rng_valid_o && $stable(rng_start_o) && $stable(rng_count_o));

  // R5
  rng_no_pix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rng_valid_o |-> !pix_rd_o);

  // R9
  eof_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !eof_o && !busy_o);

  // R8
  full_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pal_we_i || inval_i) |=> full_o);

  // R1
  px_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    px_valid_o |-> $past(pix_rd_o, 2));

  // R6
  rng_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rng_valid_o |-> rng_count_o != '0);

  // R11
  rd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_rd_o |-> busy_o);
endmodule

bind pal_scanout pal_scanout_chk #(.MAX_H(MAX_H)) i_chk (.*);

// File: tb/test_pal_scanout.sv
module test_pal_scanout;
  localparam int MAX_W = 8;
  localparam int MAX_H = 8;
  localparam int XW = $clog2(MAX_W + 1);
  localparam int YW = $clog2(MAX_H + 1);
  localparam int AW = $clog2(MAX_W * MAX_H);
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 8;
  // {width, height, dirty, inval, stall, expected region count}
  localparam logic [21:0] VEC [NVEC] = '{
    {4'd8, 4'd8, 8'h00,        1'b1, 1'b0, 4'd1},
    {4'd4, 4'd6, 8'b0011_0110, 1'b0, 1'b0, 4'd2},
    {4'd3, 4'd8, 8'b1000_0001, 1'b0, 1'b1, 4'd2},
    {4'd5, 4'd5, 8'b1110_0000, 1'b0, 1'b0, 4'd0},
    {4'd8, 4'd8, 8'hFF,        1'b0, 1'b1, 4'd1},
    {4'd1, 4'd8, 8'b0101_0101, 1'b0, 1'b0, 4'd4},
    {4'd2, 4'd3, 8'h00,        1'b1, 1'b0, 4'd1},
    {4'd8, 4'd1, 8'h01,        1'b0, 1'b1, 4'd1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, inval_i = 1'b0, pal_we_i = 1'b0;
  logic [XW-1:0] width_i = '0;
  logic [YW-1:0] height_i = '0;
  logic [MAX_H-1:0] dirty_i = '0;
  logic [7:0] pal_idx_i = '0;
  logic [23:0] pal_rgb_i = '0;
  logic pix_rd_o, px_valid_o, rng_valid_o, eof_o, busy_o, full_o;
  logic [AW-1:0] pix_addr_o;
  logic [7:0] pix_idx_i = '0;
  logic [31:0] px_rgb_o;
  logic [YW-1:0] rng_start_o, rng_count_o;
  logic rdy = 1'b1;
  logic stall_en = 1'b0;

  int errors = 0, checks = 0;
  int n_px = 0, n_addr = 0, n_rng = 0, n_eof = 0;
  int got_px [1024];
  int got_addr [1024];
  int got_rs [64];
  int got_rc [64];
  bit model_full = 1'b1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pal_scanout #(.MAX_W(MAX_W), .MAX_H(MAX_H)) i_pal_scanout (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .width_i(width_i),
    .height_i(height_i), .dirty_i(dirty_i), .inval_i(inval_i),
    .pal_we_i(pal_we_i), .pal_idx_i(pal_idx_i), .pal_rgb_i(pal_rgb_i),
    .pix_rd_o(pix_rd_o), .pix_addr_o(pix_addr_o), .pix_idx_i(pix_idx_i),
    .px_valid_o(px_valid_o), .px_rgb_o(px_rgb_o), .rng_valid_o(rng_valid_o),
    .rng_ready_i(rdy), .rng_start_o(rng_start_o), .rng_count_o(rng_count_o),
    .eof_o(eof_o), .busy_o(busy_o), .full_o(full_o)
  );

  function automatic logic [7:0] mem_f(int a);
    return 8'(a * 7 + 3);
  endfunction

  function automatic logic [23:0] pal_f(int i);
    return {8'(i ^ 'h5A), 8'(i + 17), 8'(~i)};
  endfunction

  always @(posedge clk) pix_idx_i <= mem_f(int'(pix_addr_o));
  always @(posedge clk) rdy <= stall_en ? ~rdy : 1'b1;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (pix_rd_o) begin got_addr[n_addr & 1023] = int'(pix_addr_o); n_addr++; end
      if (px_valid_o) begin got_px[n_px & 1023] = int'(px_rgb_o); n_px++; end
      if (rng_valid_o && rdy) begin
        got_rs[n_rng & 63] = int'(rng_start_o);
        got_rc[n_rng & 63] = int'(rng_count_o);
        n_rng++;
      end
      if (eof_o) n_eof++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // mode 0 plain, 1 restart attempt with new dirty bits, 2 invalidate mid-scan
  task automatic frame_go(int w, int h, logic [7:0] d, int mode, int exp_nr);
    int a0 = n_addr, p0 = n_px, r0 = n_rng, e0 = n_eof;
    int ers[16], erc[16];
    int ne = 0, run = 0, rs = 0, k = 0, waitc = 0;
    bit fm = model_full;
    @(negedge clk);
    width_i = XW'(w); height_i = YW'(h); dirty_i = d; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (mode == 1) begin
      start_i = 1'b1; dirty_i = 8'hFF;
      @(negedge clk); @(negedge clk);
      start_i = 1'b0;
    end
    if (mode == 2) begin
      @(negedge clk);
      inval_i = 1'b1;
      @(negedge clk);
      inval_i = 1'b0;
    end
    while (n_eof == e0 && waitc < 5000) begin @(negedge clk); waitc++; end
    chk(waitc < 5000, "R9 eof seen", waitc, 0);
    repeat (4) @(negedge clk);
    chk(n_eof - e0 == 1, "R9 one eof", n_eof - e0, 1);
    chk(!busy_o, "R9 idle after eof", busy_o, 0);
    // model
    for (int r = 0; r < h; r++) begin
      if (fm || d[r]) begin
        if (run == 0) rs = r;
        run++;
      end else if (run != 0) begin
        ers[ne] = rs; erc[ne] = run; ne++; run = 0;
      end
    end
    if (run != 0) begin ers[ne] = rs; erc[ne] = run; ne++; end
    if (exp_nr >= 0) chk(ne == exp_nr, "R12 table region count", ne, exp_nr);
    chk(n_rng - r0 == ne, fm ? "R3 region count" : "R5 region count", n_rng - r0, ne);
    for (int i = 0; i < ne && i < n_rng - r0; i++) begin
      chk(got_rs[(r0 + i) & 63] == ers[i], "R5 region start", got_rs[(r0 + i) & 63], ers[i]);
      chk(got_rc[(r0 + i) & 63] == erc[i], "R6 region count", got_rc[(r0 + i) & 63], erc[i]);
    end
    k = 0;
    for (int r = 0; r < h; r++) begin
      if (fm || d[r]) begin
        for (int c = 0; c < w; c++) begin
          if (k < n_addr - a0)
            chk(got_addr[(a0 + k) & 1023] == r * w + c, "R4 address",
                got_addr[(a0 + k) & 1023], r * w + c);
          if (k < n_px - p0)
            chk(got_px[(p0 + k) & 1023] == int'({8'h00, pal_f(int'(mem_f(r * w + c)))}),
                "R1 pixel", got_px[(p0 + k) & 1023], int'({8'h00, pal_f(int'(mem_f(r * w + c)))}));
          k++;
        end
      end
    end
    chk(n_addr - a0 == k, "R4 read count", n_addr - a0, k);
    chk(n_px - p0 == k, "R1 pixel count", n_px - p0, k);
    model_full = (mode == 2);
    chk(full_o == model_full, "R7 flag after frame", full_o, model_full);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2
    chk(!busy_o && !px_valid_o && !rng_valid_o && !eof_o, "R2 idle outputs",
        {busy_o, px_valid_o, rng_valid_o, eof_o}, 0);
    chk(full_o == 1'b1, "R2 full flag", full_o, 1);
    rst_ni = 1'b1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      pal_we_i = 1'b1; pal_idx_i = 8'(i); pal_rgb_i = pal_f(i);
    end
    @(negedge clk);
    pal_we_i = 1'b0;
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][5]) begin
        @(negedge clk); inval_i = 1'b1;
        @(negedge clk); inval_i = 1'b0;
        model_full = 1'b1;
        chk(full_o, "R8 invalidate", full_o, 1);
      end
      stall_en = VEC[v][4];
      frame_go(int'(VEC[v][21:18]), int'(VEC[v][17:14]), VEC[v][13:6], 0, int'(VEC[v][3:0]));
    end
    stall_en = 1'b0;
    // R11: restart attempt while busy with changed dirty bits
    frame_go(2, 4, 8'h01, 1, 1);
    // R7: invalidate during a scan keeps the flag armed
    frame_go(8, 8, 8'h00, 2, 0);
    frame_go(3, 4, 8'h00, 0, 1);
    // R8: palette write after the flag was cleared
    @(negedge clk);
    pal_we_i = 1'b1; pal_idx_i = 8'd9; pal_rgb_i = pal_f(9);
    @(negedge clk);
    pal_we_i = 1'b0;
    chk(full_o, "R8 table write", full_o, 1);
    model_full = 1'b1;
    stall_en = 1'b1;
    frame_go(4, 5, 8'h00, 0, 1);
    stall_en = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end
endmodule